// File: doc/BRIEF.md
# OTP Fuse Array Register Interface

This block puts a bank of 32-bit control registers in front of a small one-time-programmable fuse array. Software sets a fuse index and a group of control registers: chip enable, data strobe, trim, program, clock, write enable and several test registers. It then reads a data-out register to get the 32-bit word at that index. The block does not model programming. The fuse contents follow directly from reset: every word is erased to all ones, except a serial-number word and the bitwise complement of that word, which sit at two neighbouring indices.

The data-out register returns fuse contents only when three separate enable bits are set: bit 0 of chip enable, bit 0 of data strobe and bit 0 of trim. In every other case it returns the constant 0xFF. Any write to an offset that is unmapped or not word-aligned is dropped, and it sets a sticky error output that only reset clears. Reads are combinational and complete in the same cycle as the strobe. The block uses a synchronous, active-low reset. The serial value is taken from an input port while reset is held.

Top module: `otp_fuse_regif`

## Requirements
- R1: While reset is held and after it is released, every control register reads 0 and `access_err` is 0.
- R2: The registers live at word offsets 0x00 to 0x38 in this order: address, address-IO, address-strobe, chip-enable, clock, data-in, data-out, data-strobe, program, test-control, test-mode, test-mode-repeat, test-row, trim, write-enable. Every register except address and data-out reads back the full 32-bit value last written to it.
- R3: A write to the address register (0x00) stores the written value ANDed with 0xFFF. That stored value is the fuse index.
- R4: With bit 0 set in chip-enable (0x0C), data-strobe (0x1C) and trim (0x34), a read of data-out (0x18) returns the fuse word at the index held in the address register.
- R5: If any one of those three enable bits is clear, a read of data-out returns 0x000000FF.
- R6: A write to data-out changes no register and does not set `access_err`.
- R7: Every fuse word reads 0xFFFFFFFF, except the two serial-number words.
- R8: Fuse index 0xFC holds the value that `serial_i` had during the last reset cycle. Index 0xFD holds its bitwise complement. Later changes on `serial_i` do not affect either word.
- R9: A read at an offset of 0x3C or higher, or at an offset that is not a multiple of 4, returns 0.
- R10: A write to an unmapped offset changes no register and sets `access_err` from the next clock edge. The flag stays set until reset.
- R11: `rdata` is valid in the same cycle as `rd_en` and is 0 whenever `rd_en` is low.
- R12: Bits above bit 0 in chip-enable, data-strobe and trim are stored but have no effect on gating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| serial_i | input | 32 | Serial number captured while reset is held |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | BUS_AW (8) | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| access_err | output | 1 | Sticky flag for writes to unmapped offsets |

## Verification
A write takes effect at the clock edge that samples it. Any read issued in a later cycle, and `access_err`, show the effect from the following falling edge onward. Read data is combinational, so it is due in the same cycle as `rd_en`. The bench drives each access at a falling edge and samples `rdata` a short delay later, before the next rising edge. It only checks the effect of a write after the rising edge that commits the write. A second reset with a different serial value checks that the serial words and the error flag are reloaded.

// File: rtl/otp_regif_pkg.sv
package otp_regif_pkg;

  localparam int NREG = 15;

  typedef enum logic [3:0] {
    RA_ADDR  = 4'd0,
    RA_AIO   = 4'd1,
    RA_ASTB  = 4'd2,
    RA_CE    = 4'd3,
    RA_CLK   = 4'd4,
    RA_DIN   = 4'd5,
    RA_DOUT  = 4'd6,
    RA_DSTB  = 4'd7,
    RA_PROG  = 4'd8,
    RA_TCTL  = 4'd9,
    RA_TMODE = 4'd10,
    RA_TREP  = 4'd11,
    RA_TROW  = 4'd12,
    RA_TRIM  = 4'd13,
    RA_WEN   = 4'd14
  } reg_id_e;

  localparam logic [31:0] ERASED_WORD = 32'hFFFF_FFFF;
  localparam logic [31:0] GATED_WORD  = 32'h0000_00FF;

  // Contents of one fuse word as a function of its index.
  function automatic logic [31:0] fuse_word(input logic [31:0] idx,
                                            input logic [31:0] sidx,
                                            input logic [31:0] ser);
    if (idx == sidx)           return ser;
    else if (idx == sidx + 1)  return ~ser;
    else                       return ERASED_WORD;
  endfunction

  // True when a byte offset selects a register.
  function automatic logic offset_mapped(input logic [31:0] off);
    return (off[1:0] == 2'b00) && ((off >> 2) < NREG);
  endfunction

endpackage

// File: rtl/otp_addr_decode.sv
module otp_addr_decode
  import otp_regif_pkg::*;
#(
  parameter int BUS_AW = 8
) (
  input  logic [BUS_AW-1:0] addr,
  output logic              hit,
  output logic [3:0]        reg_idx
);
  logic [31:0] off32;
  logic [31:0] word;

  always_comb begin
    off32   = 32'(addr);
    word    = off32 >> 2;
    hit     = offset_mapped(off32);
    reg_idx = word[3:0];
  end
endmodule

// File: rtl/otp_reg_bank.sv
module otp_reg_bank
  import otp_regif_pkg::*;
#(
  parameter int FUSE_AW = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       hit,
  input  logic [3:0]                 reg_idx,
  input  logic [31:0]                wdata,
  output logic [NREG-1:0][31:0]      regs_q
);
  localparam logic [31:0] ADDR_MASK = 32'((64'd1 << FUSE_AW) - 1);

  logic [NREG-1:0] wr_hit;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign wr_hit[i] = wr_en && hit && (reg_idx == 4'(i));
    if (i == int'(RA_DOUT)) begin : g_ro
      assign regs_q[i] = '0;
    end else if (i == int'(RA_ADDR)) begin : g_addr
      logic [31:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)         q <= '0;
        else if (wr_hit[i]) q <= wdata & ADDR_MASK;
      end
      assign regs_q[i] = q;
    end else begin : g_rw
      logic [31:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)         q <= '0;
        else if (wr_hit[i]) q <= wdata;
      end
      assign regs_q[i] = q;
    end
  end

  // R3
  addr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit[RA_ADDR] |=> regs_q[RA_ADDR] == ($past(wdata) & ADDR_MASK));

  // R6
  dout_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit && reg_idx == RA_DOUT) |=> $stable(regs_q));
endmodule

// File: rtl/otp_fuse_store.sv
module otp_fuse_store
  import otp_regif_pkg::*;
#(
  parameter int FUSE_AW    = 12,
  parameter int SERIAL_IDX = 'hFC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [31:0]        serial_i,
  input  logic [FUSE_AW-1:0] fuse_idx,
  output logic [31:0]        fuse_data
);
  logic [31:0] serial_q;

  always_ff @(posedge clk) begin
    if (!rst_n) serial_q <= serial_i;
  end

  assign fuse_data = fuse_word(32'(fuse_idx), 32'(SERIAL_IDX), serial_q);

  // R8
  serial_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(serial_q));
endmodule

// File: rtl/otp_fuse_regif.sv
module otp_fuse_regif
  import otp_regif_pkg::*;
#(
  parameter int BUS_AW     = 8,
  parameter int FUSE_AW    = 12,
  parameter int SERIAL_IDX = 'hFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       serial_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BUS_AW-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              access_err
);
  logic                  hit;
  logic [3:0]            reg_idx;
  logic [NREG-1:0][31:0] regs_q;
  logic [31:0]           fuse_data;
  logic                  array_enabled;
  logic                  bad_write;

  otp_addr_decode #(.BUS_AW(BUS_AW)) u_dec (
    .addr    (addr),
    .hit     (hit),
    .reg_idx (reg_idx)
  );

  otp_reg_bank #(.FUSE_AW(FUSE_AW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .hit     (hit),
    .reg_idx (reg_idx),
    .wdata   (wdata),
    .regs_q  (regs_q)
  );

  otp_fuse_store #(.FUSE_AW(FUSE_AW), .SERIAL_IDX(SERIAL_IDX)) u_fuse (
    .clk       (clk),
    .rst_n     (rst_n),
    .serial_i  (serial_i),
    .fuse_idx  (regs_q[RA_ADDR][FUSE_AW-1:0]),
    .fuse_data (fuse_data)
  );

  assign array_enabled = regs_q[RA_CE][0] & regs_q[RA_DSTB][0] & regs_q[RA_TRIM][0];
  assign bad_write     = wr_en && !hit;

  always_comb begin
    rdata = '0;
    if (rd_en && hit) begin
      if (reg_idx == RA_DOUT) rdata = array_enabled ? fuse_data : GATED_WORD;
      else                    rdata = regs_q[reg_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         access_err <= 1'b0;
    else if (bad_write) access_err <= 1'b1;
  end

  // R5
  gated_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit && reg_idx == RA_DOUT && !array_enabled) |-> rdata == GATED_WORD);

  // R10
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_write |=> access_err);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    access_err |=> access_err);

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == 32'd0);

  // R9
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit) |-> rdata == 32'd0);
endmodule

// File: tb/otp_fuse_regif_test.sv
module otp_fuse_regif_test;
  localparam int NR = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] serial_i = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        access_err;

  int checks = 0;
  int fails  = 0;
  logic [31:0] m_reg [NR];
  logic [31:0] m_ser;
  logic        m_err;

  otp_fuse_regif uut (
    .clk(clk), .rst_n(rst_n), .serial_i(serial_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .access_err(access_err)
  );

  always #10 clk = ~clk;

  function automatic logic is_mapped(input logic [7:0] off);
    return (off[1:0] == 2'b00) && (int'(off) / 4 < NR);
  endfunction

  function automatic logic [31:0] exp_fuse(input logic [11:0] i, input logic [31:0] s);
    if (i == 12'h0FC) return s;
    if (i == 12'h0FD) return ~s;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] off);
    if (!is_mapped(off)) return 32'd0;
    if (off == 8'h18) begin
      if (m_reg[3][0] && m_reg[7][0] && m_reg[13][0]) return exp_fuse(m_reg[0][11:0], m_ser);
      return 32'h0000_00FF;
    end
    return m_reg[off / 4];
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = off; wdata = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
    if (is_mapped(off) && off != 8'h18) m_reg[off / 4] = (off == 8'h00) ? (d & 32'hFFF) : d;
    else if (!is_mapped(off)) m_err = 1'b1;
  endtask

  task automatic do_read(input logic [7:0] off, input string req);
    @(negedge clk);
    rd_en = 1'b1; addr = off;
    #2 check(rdata, exp_read(off), req);
    rd_en = 1'b0;
  endtask

  task automatic do_reset(input logic [31:0] s);
    @(negedge clk);
    rst_n = 1'b0; serial_i = s;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1; serial_i = ~s ^ 32'h5A5A_0000;
    for (int i = 0; i < NR; i++) m_reg[i] = '0;
    m_ser = s; m_err = 1'b0;
  endtask

  task automatic enable_array(input logic on);
    do_write(8'h0C, {31'h0, on});
    do_write(8'h1C, 32'h1);
    do_write(8'h34, 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset(32'hC0DE_1234);
    // R1: reset state
    for (int i = 0; i < NR; i++) do_read(8'(i * 4), "R1");
    check({31'h0, access_err}, 32'd0, "R1");
    // R2: readback of every writable register
    for (int i = 1; i < NR; i++) if (i != 6) do_write(8'(i * 4), 32'hA500_0000 | 32'(i * 17));
    for (int i = 1; i < NR; i++) do_read(8'(i * 4), "R2");
    // R3: address masking
    do_write(8'h00, 32'hFFFF_FFFF);
    do_read(8'h00, "R3");
    // R4 / R8: serial words and complement
    enable_array(1'b1);
    do_write(8'h00, 32'h0000_00FC); do_read(8'h18, "R8");
    do_write(8'h00, 32'hABCD_E0FD); do_read(8'h18, "R8");
    // R7: erased words
    do_write(8'h00, 32'h0); do_read(8'h18, "R7");
    do_write(8'h00, 32'hFFF); do_read(8'h18, "R7");
    do_write(8'h00, 32'h0FE); do_read(8'h18, "R4");
    // R5 and R12: gating with upper bits set but bit 0 clear
    do_write(8'h00, 32'h0FC);
    do_write(8'h34, 32'hFFFF_FFFE); do_read(8'h18, "R12");
    do_write(8'h34, 32'h1);
    do_write(8'h0C, 32'h8000_0000); do_read(8'h18, "R5");
    do_write(8'h0C, 32'h1);
    do_write(8'h1C, 32'h0); do_read(8'h18, "R5");
    do_write(8'h1C, 32'h3); do_read(8'h18, "R4");
    // R6: write to data-out
    do_write(8'h18, 32'h1234_5678);
    for (int i = 0; i < NR; i++) do_read(8'(i * 4), "R6");
    check({31'h0, access_err}, 32'd0, "R6");
    // R9: unmapped reads
    do_read(8'h3C, "R9"); do_read(8'h40, "R9"); do_read(8'h01, "R9"); do_read(8'hFE, "R9");
    // R11: idle read port
    @(negedge clk); addr = 8'h04; #2 check(rdata, 32'd0, "R11");
    // R10: unmapped write sets sticky flag, changes nothing
    do_write(8'h3D, 32'hDEAD_BEEF);
    @(negedge clk); check({31'h0, access_err}, 32'd1, "R10");
    for (int i = 0; i < NR; i++) do_read(8'(i * 4), "R10");
    do_write(8'h10, 32'h7);
    @(negedge clk); check({31'h0, access_err}, 32'd1, "R10");
    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [7:0] off;
      logic [31:0] d;
      off = ($urandom % 8 == 0) ? 8'($urandom) : 8'(($urandom % 16) * 4);
      d = $urandom;
      if (off == 8'h00 && $urandom % 2 == 0) d = 32'h0FC + 32'($urandom % 3);
      if ((off == 8'h0C || off == 8'h1C || off == 8'h34) && $urandom % 4 != 0) d[0] = 1'b1;
      if ($urandom % 2 == 0) do_write(off, d);
      else do_read(off, "R2");
      if ($urandom % 4 == 0) do_read(8'h18, "R4");
      @(negedge clk); check({31'h0, access_err}, {31'h0, m_err}, "R10");
    end
    // R1 / R8: second reset reloads serial and clears flag
    do_reset(32'h0BAD_F00D);
    check({31'h0, access_err}, 32'd0, "R1");
    enable_array(1'b1);
    do_write(8'h00, 32'h0FC); do_read(8'h18, "R8");
    do_write(8'h00, 32'h0FD); do_read(8'h18, "R8");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule